// File: doc/BRIEF.md
# Real-Time Clock Update Cycle and Alarm Matcher

This block keeps a time of day (seconds, minutes, hours) and moves it forward once per second. The second is counted from a one-cycle tick that pulses once per period of a 32.768 kHz reference. Shortly before each once-per-second update, an update-in-progress indication goes high so that software reading the time knows a rollover is about to happen.

At every update the block compares the new time with three alarm bytes. An alarm byte with its two top bits set acts as a wildcard. Each update sets an update-ended flag. A match also sets an alarm flag. The interrupt output is raised when a flag goes from clear to set while its enable input is high. Time is shown and loaded either as packed BCD or as plain binary, and the hours are either 24-hour or 12-hour with a PM bit. Flags and the interrupt are cleared together by a read-clear pulse.

The divider control input selects one of three states. Codes 000 to 010 mean running. Codes whose bits 2:1 are both 1 hold the divider in reset. Any other code leaves the divider counting while the time stands still. The set input freezes the time without stopping the update cycle.

Top module: `rtc_update_alarm`

## Requirements
- R1: After reset the time is 00:00:00, with the hours byte reading 0x12 in 12-hour BCD mode. UF, AF, irq_o and uip_o are all 0, and the sub-second count is 0.
- R2: While div_ctl_i[2:1] is 11, no update occurs, UF and AF do not rise, the time does not change, and uip_o is 0.
- R3: The time advances at an update only when div_ctl_i is at most 010 and set_i is 0. Otherwise the update still happens but the time holds.
- R4: When div_ctl_i leaves the reset state, the first update comes after TICKS_PER_SEC/2 ticks.
- R5: uip_o is 1 while running and during the last UIP_TICKS ticks before an update. It is 0 once the update has completed.
- R6: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0.
- R7: In 12-hour mode (h24_i = 0) the hours byte holds 1 to 12, with bit 7 set for PM. 11 PM is followed by 12 AM, 12 AM by 1 AM, and 12 PM by 1 PM.
- R8: With bin_i = 0 each byte is packed BCD, with the tens digit in bits 7:4. With bin_i = 1 each byte is the plain binary value.
- R9: Every update sets UF. UF stays set until flag_clr_i.
- R10: At an update AF is set when each alarm byte either has bits 7:6 equal to 11 or equals the updated time field.
- R11: In 12-hour mode an alarm hours byte is compared as its value modulo 12, plus 12 when bit 7 is set.
- R12: irq_o is set only in a cycle where UF goes from clear to set with ue_en_i = 1, or AF goes from clear to set with ae_en_i = 1. In the same cycle that flag_clr_i is applied, UF, AF and irq_o are cleared, and any flag set at that cycle's update counts as newly set.
- R13: A ld_i pulse loads all three time fields, decoded in the current BCD/binary and 12/24-hour format. A load takes priority over an update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One pulse per reference-oscillator period |
| div_ctl_i | input | 3 | Divider control: 000 to 010 run, 11x hold divider in reset |
| set_i | input | 1 | Freeze the time |
| bin_i | input | 1 | 1 = binary fields, 0 = packed BCD |
| h24_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| ue_en_i | input | 1 | Update-ended interrupt enable |
| ae_en_i | input | 1 | Alarm interrupt enable |
| ld_i | input | 1 | Load time from ld_*_i |
| ld_sec_i | input | 8 | Seconds value to load |
| ld_min_i | input | 8 | Minutes value to load |
| ld_hr_i | input | 8 | Hours value to load |
| alm_sec_i | input | 8 | Alarm seconds (11xxxxxx = any) |
| alm_min_i | input | 8 | Alarm minutes (11xxxxxx = any) |
| alm_hr_i | input | 8 | Alarm hours (11xxxxxx = any) |
| flag_clr_i | input | 1 | Read-clear of UF, AF and irq_o |
| sec_o | output | 8 | Seconds in current format |
| min_o | output | 8 | Minutes in current format |
| hr_o | output | 8 | Hours in current format |
| uip_o | output | 1 | Update in progress |
| uf_o | output | 1 | Update-ended flag |
| af_o | output | 1 | Alarm flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong sub-second count shows up at the next second. uip_o rises or UF sets a cycle early or late, and the half-second start after a divider release lands on the wrong cycle. A wrong time register shows on the time bytes in the same cycle, because the outputs are formatted directly from the stored binary value. A bad carry shows up at the first 59 or 23 boundary. A wrong flag or match result shows as an AF or irq_o edge one cycle after the offending update, or as a flag that survives a clear. Because the reference model is compared every clock, any of these is reported in the cycle where it first appears.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  function automatic logic [6:0] fld_dec(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : (7'(b[7:4]) * 7'd10 + 7'(b[3:0]));
  endfunction

  function automatic logic [7:0] fld_enc(input logic [6:0] v, input logic bin);
    logic [6:0] tens, ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
  endfunction

  // hours to 0..23 regardless of format
  function automatic logic [4:0] hr_dec(input logic [7:0] b, input logic bin, input logic h24);
    logic [6:0] v;
    if (h24) begin
      v = fld_dec(b, bin);
    end else begin
      v = fld_dec({1'b0, b[6:0]}, bin) % 7'd12;
      if (b[7]) v = v + 7'd12;
    end
    return v[4:0];
  endfunction

  function automatic logic [7:0] hr_enc(input logic [4:0] h, input logic bin, input logic h24);
    logic [4:0] m;
    logic [7:0] e;
    if (h24) return fld_enc({2'b00, h}, bin);
    m = (h >= 5'd12) ? h - 5'd12 : h;
    if (m == 5'd0) m = 5'd12;
    e = fld_enc({2'b00, m}, bin);
    return {(h >= 5'd12), e[6:0]};
  endfunction

  function automatic logic is_wild(input logic [7:0] b);
    return b[7:6] == 2'b11;
  endfunction

endpackage

// File: rtl/rtc_div.sv
module rtc_div #(
  parameter int TICKS     = 32768,
  parameter int UIP_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic div_rst_i,
  input  logic run_i,
  output logic uip_o,
  output logic upd_o
);
  localparam int CW = $clog2(TICKS);
  localparam logic [CW-1:0] LAST   = CW'(TICKS - 1);
  localparam logic [CW-1:0] HALF   = CW'(TICKS / 2);
  localparam logic [CW-1:0] UIP_AT = CW'(TICKS - UIP_TICKS);

  logic [CW-1:0] cnt_q;

  // held at half-second while in reset so release starts mid-second
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (div_rst_i) cnt_q <= HALF;
    else if (tick_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  assign upd_o = tick_i & ~div_rst_i & (cnt_q == LAST);
  assign uip_o = run_i & (cnt_q >= UIP_AT);
endmodule

// File: rtl/rtc_time.sv
module rtc_time
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hr_i,
  input  logic       bin_i,
  input  logic       h24_i,
  input  logic       step_i,
  output logic [5:0] sec_o,
  output logic [5:0] min_o,
  output logic [4:0] hr_o,
  output logic [5:0] nxt_sec_o,
  output logic [5:0] nxt_min_o,
  output logic [4:0] nxt_hr_o
);
  logic [5:0] sec_q, min_q;
  logic [4:0] hr_q;
  logic [6:0] ld_sec_b, ld_min_b;

  always_comb begin
    nxt_sec_o = sec_q;
    nxt_min_o = min_q;
    nxt_hr_o  = hr_q;
    if (step_i) begin
      if (sec_q == 6'd59) begin
        nxt_sec_o = '0;
        if (min_q == 6'd59) begin
          nxt_min_o = '0;
          nxt_hr_o  = (hr_q == 5'd23) ? '0 : hr_q + 5'd1;
        end else begin
          nxt_min_o = min_q + 6'd1;
        end
      end else begin
        nxt_sec_o = sec_q + 6'd1;
      end
    end
  end

  assign ld_sec_b = fld_dec(ld_sec_i, bin_i);
  assign ld_min_b = fld_dec(ld_min_i, bin_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
    end else if (ld_i) begin
      sec_q <= ld_sec_b[5:0];
      min_q <= ld_min_b[5:0];
      hr_q  <= hr_dec(ld_hr_i, bin_i, h24_i);
    end else begin
      sec_q <= nxt_sec_o;
      min_q <= nxt_min_o;
      hr_q  <= nxt_hr_o;
    end
  end

  assign sec_o = sec_q;
  assign min_o = min_q;
  assign hr_o  = hr_q;
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic [7:0] alm_sec_i,
  input  logic [7:0] alm_min_i,
  input  logic [7:0] alm_hr_i,
  input  logic       bin_i,
  input  logic       h24_i,
  input  logic [5:0] sec_i,
  input  logic [5:0] min_i,
  input  logic [4:0] hr_i,
  output logic       match_o
);
  localparam int NFLD = 2;

  logic [NFLD-1:0][7:0] alm;
  logic [NFLD-1:0][5:0] cur;
  logic [NFLD:0]        hit;

  assign alm = {alm_min_i, alm_sec_i};
  assign cur = {min_i, sec_i};

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    assign hit[g] = is_wild(alm[g]) | (fld_dec(alm[g], bin_i) == {1'b0, cur[g]});
  end

  assign hit[NFLD] = is_wild(alm_hr_i) | (hr_dec(alm_hr_i, bin_i, h24_i) == hr_i);
  assign match_o   = &hit;
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic match_i,
  input  logic clr_i,
  input  logic ue_en_i,
  input  logic ae_en_i,
  output logic uf_o,
  output logic af_o,
  output logic irq_o
);
  logic uf_q, af_q, irq_q;
  logic uf_b, af_b, irq_b, set_af, new_uf, new_af;

  // clear applies first, so a same-cycle set counts as new
  assign uf_b   = uf_q  & ~clr_i;
  assign af_b   = af_q  & ~clr_i;
  assign irq_b  = irq_q & ~clr_i;
  assign set_af = upd_i & match_i;
  assign new_uf = upd_i  & ~uf_b;
  assign new_af = set_af & ~af_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uf_q  <= 1'b0;
      af_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      uf_q  <= uf_b | upd_i;
      af_q  <= af_b | set_af;
      irq_q <= irq_b | (new_uf & ue_en_i) | (new_af & ae_en_i);
    end
  end

  assign uf_o  = uf_q;
  assign af_o  = af_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/rtc_update_alarm.sv
module rtc_update_alarm
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [2:0] div_ctl_i,
  input  logic       set_i,
  input  logic       bin_i,
  input  logic       h24_i,
  input  logic       ue_en_i,
  input  logic       ae_en_i,
  input  logic       ld_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hr_i,
  input  logic [7:0] alm_sec_i,
  input  logic [7:0] alm_min_i,
  input  logic [7:0] alm_hr_i,
  input  logic       flag_clr_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o,
  output logic       uip_o,
  output logic       uf_o,
  output logic       af_o,
  output logic       irq_o
);
  logic       div_rst, run, upd, match;
  logic [5:0] sec_b, min_b, nsec_b, nmin_b;
  logic [4:0] hr_b, nhr_b;

  assign div_rst = (div_ctl_i[2:1] == 2'b11);
  assign run     = ~set_i & (div_ctl_i <= 3'd2);

  rtc_div #(
    .TICKS    (TICKS_PER_SEC),
    .UIP_TICKS(UIP_TICKS)
  ) i_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .div_rst_i(div_rst),
    .run_i    (run),
    .uip_o    (uip_o),
    .upd_o    (upd)
  );

  rtc_time i_time (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (ld_i),
    .ld_sec_i (ld_sec_i),
    .ld_min_i (ld_min_i),
    .ld_hr_i  (ld_hr_i),
    .bin_i    (bin_i),
    .h24_i    (h24_i),
    .step_i   (upd & run),
    .sec_o    (sec_b),
    .min_o    (min_b),
    .hr_o     (hr_b),
    .nxt_sec_o(nsec_b),
    .nxt_min_o(nmin_b),
    .nxt_hr_o (nhr_b)
  );

  // compare against the time as it stands after this update
  rtc_alarm i_alarm (
    .alm_sec_i(alm_sec_i),
    .alm_min_i(alm_min_i),
    .alm_hr_i (alm_hr_i),
    .bin_i    (bin_i),
    .h24_i    (h24_i),
    .sec_i    (nsec_b),
    .min_i    (nmin_b),
    .hr_i     (nhr_b),
    .match_o  (match)
  );

  rtc_flags i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (upd),
    .match_i(match),
    .clr_i  (flag_clr_i),
    .ue_en_i(ue_en_i),
    .ae_en_i(ae_en_i),
    .uf_o   (uf_o),
    .af_o   (af_o),
    .irq_o  (irq_o)
  );

  assign sec_o = fld_enc({1'b0, sec_b}, bin_i);
  assign min_o = fld_enc({1'b0, min_b}, bin_i);
  assign hr_o  = hr_enc(hr_b, bin_i, h24_i);
endmodule

// File: rtl/rtc_update_alarm_chk.sv
module rtc_update_alarm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic flag_clr_i,
  input logic ue_en_i,
  input logic ae_en_i,
  input logic uip_o,
  input logic uf_o,
  input logic af_o,
  input logic irq_o,
  input logic upd,
  input logic run,
  input logic div_rst
);
  // R2
  divrst_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_rst |=> !$rose(uf_o) && !$rose(af_o));

  // R5
  uip_before_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd && run |-> uip_o);

  // R9
  uf_on_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> uf_o);

  // R9
  uf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_o && !flag_clr_i |=> uf_o);

  // R10
  af_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(af_o) |-> $past(upd));

  // R12
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(ue_en_i) && uf_o) || ($past(ae_en_i) && af_o));

  // R12
  clr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && !upd |=> !uf_o && !af_o && !irq_o);
endmodule

bind rtc_update_alarm rtc_update_alarm_chk i_rtc_update_alarm_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .flag_clr_i(flag_clr_i),
  .ue_en_i   (ue_en_i),
  .ae_en_i   (ae_en_i),
  .uip_o     (uip_o),
  .uf_o      (uf_o),
  .af_o      (af_o),
  .irq_o     (irq_o),
  .upd       (upd),
  .run       (run),
  .div_rst   (div_rst)
);

// File: tb/test_rtc_update_alarm.sv
module test_rtc_update_alarm;
  localparam int T   = 64;
  localparam int UIP = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b1;
  logic [2:0] div_ctl_i = 3'b010;
  logic set_i = 1'b0, bin_i = 1'b0, h24_i = 1'b1;
  logic ue_en_i = 1'b1, ae_en_i = 1'b0, ld_i = 1'b0, flag_clr_i = 1'b0;
  logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hr_i = '0;
  logic [7:0] alm_sec_i = 8'hff, alm_min_i = 8'hff, alm_hr_i = 8'hff;
  logic [7:0] sec_o, min_o, hr_o;
  logic uip_o, uf_o, af_o, irq_o;

  rtc_update_alarm #(.TICKS_PER_SEC(T), .UIP_TICKS(UIP)) i_rtc_update_alarm (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_en = 0, done = 0;
  string phase = "R1";

  // reference model state
  int m_cnt = 0, m_s = 0, m_m = 0, m_h = 0, m_uf = 0, m_af = 0, m_irq = 0;

  function automatic int dec(int b, int bin);
    return bin ? b : ((b >> 4) * 10 + (b & 15));
  endfunction
  function automatic int enc(int v, int bin);
    return bin ? v : (((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int hdec(int b, int bin, int h24);
    if (h24) return dec(b, bin);
    return (dec(b & 127, bin) % 12) + (((b & 128) != 0) ? 12 : 0);
  endfunction
  function automatic int henc(int h, int bin, int h24);
    int h12;
    if (h24) return enc(h, bin);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    return enc(h12, bin) | ((h >= 12) ? 128 : 0);
  endfunction
  function automatic bit fhit(int a, int v, int bin);
    return ((a & 'hc0) == 'hc0) || (dec(a, bin) == v);
  endfunction
  function automatic bit mrun();
    return !set_i && (div_ctl_i <= 3'd2);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_s = 0; m_m = 0; m_h = 0; m_uf = 0; m_af = 0; m_irq = 0;
    end else begin
      bit drst, upd, match;
      int ns, nm, nh, bu, ba, bi;
      drst = (div_ctl_i[2:1] == 2'b11);
      upd  = tick_i && !drst && (m_cnt == T - 1);
      if (drst) m_cnt = T / 2;
      else if (tick_i) m_cnt = (m_cnt + 1) % T;
      ns = m_s; nm = m_m; nh = m_h;
      if (upd && mrun()) begin
        ns++;
        if (ns == 60) begin
          ns = 0; nm++;
          if (nm == 60) begin nm = 0; nh = (nh + 1) % 24; end
        end
      end
      match = fhit(alm_sec_i, ns, bin_i) && fhit(alm_min_i, nm, bin_i) &&
              (((alm_hr_i & 'hc0) == 'hc0) || hdec(alm_hr_i, bin_i, h24_i) == nh);
      if (ld_i) begin
        m_s = dec(ld_sec_i, bin_i); m_m = dec(ld_min_i, bin_i); m_h = hdec(ld_hr_i, bin_i, h24_i);
      end else begin
        m_s = ns; m_m = nm; m_h = nh;
      end
      bu = flag_clr_i ? 0 : m_uf;
      ba = flag_clr_i ? 0 : m_af;
      bi = flag_clr_i ? 0 : m_irq;
      m_irq = (bi || (upd && !bu && ue_en_i) || (upd && match && !ba && ae_en_i)) ? 1 : 0;
      m_uf  = (bu || upd) ? 1 : 0;
      m_af  = (ba || (upd && match)) ? 1 : 0;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL [%s] %s act=%0h exp=%0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    #2;
    if (cmp_en && !done) begin
      chk("sec",  int'(sec_o), enc(m_s, bin_i));
      chk("min",  int'(min_o), enc(m_m, bin_i));
      chk("hr",   int'(hr_o),  henc(m_h, bin_i, h24_i));
      chk("uip",  int'(uip_o), (mrun() && m_cnt >= T - UIP) ? 1 : 0);
      chk("uf",   int'(uf_o),  m_uf);
      chk("af",   int'(af_o),  m_af);
      chk("irq",  int'(irq_o), m_irq);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL [watchdog] run did not end act=%0d exp=%0d", cyc, 50000);
      finish_run();
    end
  end

  task automatic run(int n, int clr_every, bit rnd_tick);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      flag_clr_i = (clr_every != 0) && (i % clr_every == clr_every - 1);
      tick_i = rnd_tick ? 1'($urandom_range(0, 1)) : 1'b1;
    end
    @(negedge clk_i);
    flag_clr_i = 1'b0;
    tick_i = 1'b1;
  endtask

  task automatic load(int s, int m, int h);
    @(negedge clk_i);
    ld_i = 1'b1; ld_sec_i = 8'(s); ld_min_i = 8'(m); ld_hr_i = 8'(h);
    @(negedge clk_i);
    ld_i = 1'b0;
  endtask

  initial begin
    // R1 reset state
    cmp_en = 1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    run(2, 0, 0);

    phase = "R13 load";
    load('h58, 'h59, 'h23);
    phase = "R5 R6 R8 R9 R12 rollover";
    run(3 * T, 50, 0);

    phase = "R10 R12 alarm";
    alm_sec_i = 8'h02; alm_min_i = 8'hc0; alm_hr_i = 8'hff; ae_en_i = 1'b1;
    run(6 * T, 64, 0);

    phase = "R7 R11 12h";
    h24_i = 1'b0; alm_hr_i = 8'h12; alm_min_i = 8'hc0; alm_sec_i = 8'hc0;
    load('h58, 'h59, 'h91);
    run(3 * T, 40, 0);
    phase = "R7 R13 noon";
    load('h59, 'h59, 'h92);
    run(2 * T, 30, 0);

    phase = "R8 R10 binary";
    bin_i = 1'b1; h24_i = 1'b1;
    alm_sec_i = 8'd33; alm_min_i = 8'd20; alm_hr_i = 8'd10;
    load(30, 20, 10);
    run(5 * T, 64, 0);

    phase = "R3 R9 set";
    set_i = 1'b1;
    run(3 * T, 100, 0);
    set_i = 1'b0;

    phase = "R2 divider reset";
    div_ctl_i = 3'b110;
    run(2 * T, 20, 0);
    phase = "R4 R5 release";
    div_ctl_i = 3'b010;
    run(2 * T, 0, 0);

    phase = "R3 stopped";
    div_ctl_i = 3'b100;
    run(T, 25, 0);
    div_ctl_i = 3'b010;

    phase = "R12 disabled";
    ue_en_i = 1'b0; ae_en_i = 1'b0; alm_sec_i = 8'hc0; alm_min_i = 8'hc0; alm_hr_i = 8'hc0;
    run(2 * T, 70, 0);
    phase = "R12 enabled";
    ue_en_i = 1'b1; ae_en_i = 1'b1;
    run(2 * T, 70, 0);

    phase = "R5 R6 R8 gapped";
    bin_i = 1'b0;
    load('h50, 'h59, 'h23);
    run(8 * T, 90, 1);

    finish_run();
  end
endmodule